// File: doc/BRIEF.md
# Compression Marker Collision Table

This block sits in a memory controller that packs pairs of compressible lines into one memory location and tags such a location with a 32-bit marker word stored inside the line. A read then learns from one access whether it fetched a compressed pair. No separate metadata lookup is needed. An uncompressed line can, by chance, hold a first word equal to the marker. The block keeps a small associative table of the line addresses of such colliding lines, so those reads are not taken for pairs.

On every line write the controller presents the address, the line's marker-position word, and whether the line is stored as a compressed pair. The block then adds the address to the table, removes it, or leaves the table alone. On every read the block compares the word with the programmed marker. It checks all valid entries in parallel in the same cycle and returns a pair or collision verdict. A new collision that finds the table full raises a sticky overflow flag. Higher-level logic can then choose a new marker. Writing a new marker empties the table and clears the flag.

Top module: `marker_collision_table`

## Requirements
- R1: A read (`rd_valid`=1) whose word equals the marker and whose address is not in the table gives `rd_is_pair`=1 and `rd_is_collision`=0 in the same cycle.
- R2: A write with `wr_compressed`=0 whose word equals the marker records its address. Later reads of that address with the marker word give `rd_is_collision`=1 and `rd_is_pair`=0.
- R3: Recording an address that is already present adds no entry. A table of ENTRIES slots holds ENTRIES distinct addresses even after repeated inserts.
- R4: A read whose word differs from the marker, or any cycle with `rd_valid`=0, gives `rd_is_pair`=0 and `rd_is_collision`=0.
- R5: A write with `wr_compressed`=0 whose word differs from the marker removes its address if present. It has no effect on other entries when the address is absent.
- R6: A write with `wr_compressed`=1 removes any entry for its address, whatever its word.
- R7: A new collision that arrives while all entries are valid sets `overflow`=1 and is not recorded. `overflow` stays set through later writes until the next marker write.
- R8: A cycle with `marker_we`=1 loads `marker_wdata` as the marker, empties the table and clears `overflow`. A data write in that same cycle is ignored.
- R9: A read reflects the table state before the clock edge. A write in the same cycle affects only reads in later cycles.
- R10: After reset the table is empty, `overflow`=0 and the marker equals parameter MARKER_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| marker_we | input | 1 | Load a new marker value |
| marker_wdata | input | WORD_W | New marker value |
| wr_valid | input | 1 | A line write is presented |
| wr_addr | input | ADDR_W | Line address of the write |
| wr_word | input | WORD_W | Word at the marker position of the written line |
| wr_compressed | input | 1 | Line is stored as a compressed pair |
| rd_valid | input | 1 | A line read is presented |
| rd_addr | input | ADDR_W | Line address of the read |
| rd_word | input | WORD_W | Word at the marker position of the fetched line |
| rd_is_pair | output | 1 | Fetched line is a compressed pair |
| rd_is_collision | output | 1 | Fetched line is uncompressed and carries the marker by chance |
| overflow | output | 1 | Sticky: a collision was lost because the table was full |

## Verification
The assertions check on every cycle that the two read verdicts never occur together, and that both stay low when no read is presented. They also check that a repeated insert leaves the count of valid entries unchanged, that a compressed write never grows the table, and that overflow rises only from a full table. They check too that a marker write leaves an empty table with the flag clear. Only the bench scenarios show the full behaviour seen at the ports. These cover which addresses end up classified as collisions after long mixed sequences of inserts and removals, and the reuse of freed slots. They also cover that a lost collision reads as a pair, the read-before-write ordering within a cycle, and the ignored write during a marker change.

// File: rtl/mct_pkg.sv
package mct_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_RECORD = 2'd1,
    ACT_DROP   = 2'd2
  } mct_act_e;
endpackage

// File: rtl/mct_match.sv
module mct_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic [ENTRIES-1:0]        valid,
  input  logic [ENTRIES*ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]         key,
  output logic [ENTRIES-1:0]        hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = valid[g] && (tags[g*ADDR_W +: ADDR_W] == key);
  end
endmodule

// File: rtl/mct_pick.sv
module mct_pick #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // lowest-numbered free slot wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mct_store.sv
module mct_store #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_all,
  input  logic                      ins_en,
  input  logic [IDX_W-1:0]          ins_idx,
  input  logic [ADDR_W-1:0]         ins_tag,
  input  logic [ENTRIES-1:0]        drop_mask,
  output logic [ENTRIES-1:0]        valid,
  output logic [ENTRIES*ADDR_W-1:0] tags
);
  logic [ENTRIES-1:0] valid_d;

  always_comb begin
    valid_d = valid & ~drop_mask;
    if (ins_en) valid_d[ins_idx] = 1'b1;
    if (clear_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else        valid <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tag
    logic tag_en;
    assign tag_en = ins_en && (ins_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (tag_en) tags[g*ADDR_W +: ADDR_W] <= ins_tag;
    end
  end
endmodule

// File: rtl/marker_collision_table.sv
module marker_collision_table
  import mct_pkg::*;
#(
  parameter int          ENTRIES     = 16,
  parameter int          ADDR_W      = 32,
  parameter int          WORD_W      = 32,
  parameter logic [31:0] MARKER_INIT = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              marker_we,
  input  logic [WORD_W-1:0] marker_wdata,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_compressed,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic              rd_is_pair,
  output logic              rd_is_collision,
  output logic              overflow
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [WORD_W-1:0]         marker_q, marker_d;
  logic                      ovf_q, ovf_d;
  logic [ENTRIES-1:0]        valid;
  logic [ENTRIES*ADDR_W-1:0] tags;
  logic [ENTRIES-1:0]        wr_hit, rd_hit, drop_mask;
  logic                      free_found, ins_en;
  logic [IDX_W-1:0]          free_idx;
  mct_act_e                  act;

  mct_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_wr_match (
    .valid(valid), .tags(tags), .key(wr_addr), .hit(wr_hit));
  mct_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_rd_match (
    .valid(valid), .tags(tags), .key(rd_addr), .hit(rd_hit));
  mct_pick #(.ENTRIES(ENTRIES)) u_pick (
    .valid(valid), .found(free_found), .idx(free_idx));

  // write-side decision
  always_comb begin
    act = ACT_NONE;
    if (!marker_we && wr_valid) begin
      if (!wr_compressed && (wr_word == marker_q)) begin
        if (!(|wr_hit)) act = ACT_RECORD;
      end else begin
        act = ACT_DROP;
      end
    end
    ins_en    = (act == ACT_RECORD) && free_found;
    drop_mask = (act == ACT_DROP) ? wr_hit : '0;
    marker_d  = marker_we ? marker_wdata : marker_q;
    ovf_d     = marker_we ? 1'b0 : (ovf_q || ((act == ACT_RECORD) && !free_found));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      marker_q <= WORD_W'(MARKER_INIT);
      ovf_q    <= 1'b0;
    end else begin
      marker_q <= marker_d;
      ovf_q    <= ovf_d;
    end
  end

  mct_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_i_n), .clear_all(marker_we), .ins_en(ins_en),
    .ins_idx(free_idx), .ins_tag(wr_addr), .drop_mask(drop_mask),
    .valid(valid), .tags(tags));

  // read-side verdict, same cycle
  logic rd_match;
  assign rd_match        = rd_valid && (rd_word == marker_q);
  assign rd_is_pair      = rd_match && !(|rd_hit);
  assign rd_is_collision = rd_match && (|rd_hit);
  assign overflow        = ovf_q;
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               marker_we,
  input logic               wr_valid,
  input logic               wr_compressed,
  input logic [WORD_W-1:0]  wr_word,
  input logic               rd_valid,
  input logic               rd_is_pair,
  input logic               rd_is_collision,
  input logic               overflow,
  input logic [WORD_W-1:0]  marker,
  input logic [ENTRIES-1:0] valid,
  input logic [ENTRIES-1:0] wr_hit
);
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_is_pair && rd_is_collision));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!rd_is_pair && !rd_is_collision));

  a_r3_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !marker_we && !wr_compressed && (wr_word == marker) && (|wr_hit))
    |=> ($countones(valid) == $past($countones(valid))));

  a_r6_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !marker_we && wr_compressed)
    |=> ($countones(valid) <= $past($countones(valid))));

  a_r7_full_before_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(&valid));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    marker_we |=> ((valid == '0) && !overflow));
endmodule

bind marker_collision_table mct_checker #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .marker_we(marker_we), .wr_valid(wr_valid),
  .wr_compressed(wr_compressed), .wr_word(wr_word), .rd_valid(rd_valid),
  .rd_is_pair(rd_is_pair), .rd_is_collision(rd_is_collision),
  .overflow(overflow), .marker(marker_q), .valid(valid), .wr_hit(wr_hit));

// File: tb/tb_marker_collision_table.sv
module tb_marker_collision_table;
  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam logic [31:0] MK0 = 32'hA5C3_0F1E;

  logic clk = 1'b0;
  logic rst_n;
  logic marker_we, wr_valid, wr_compressed, rd_valid;
  logic [31:0] marker_wdata, wr_addr, wr_word, rd_addr, rd_word;
  logic rd_is_pair, rd_is_collision, overflow;

  always #(CLK_P/2) clk = ~clk;

  marker_collision_table dut (
    .clk(clk), .rst_n(rst_n), .marker_we(marker_we), .marker_wdata(marker_wdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_word(wr_word),
    .wr_compressed(wr_compressed), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_word(rd_word), .rd_is_pair(rd_is_pair), .rd_is_collision(rd_is_collision),
    .overflow(overflow));

  int total = 0, bad = 0;
  bit done = 0;
  bit mdl [128];
  int cnt;
  bit ovf_m;
  logic [31:0] mk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input int a, input logic [31:0] w, input string tag);
    bit ep, ec;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_word = w;
    #1;
    ec = (w == mk) && mdl[a];
    ep = (w == mk) && !mdl[a];
    chk({rd_is_pair, rd_is_collision} == {ep, ec}, tag,
        {rd_is_pair, rd_is_collision}, {ep, ec});
    rd_valid = 1'b0;
  endtask

  task automatic model_wr(input int a, input logic [31:0] w, input bit comp);
    if (!comp && w == mk) begin
      if (!mdl[a]) begin
        if (cnt < N) begin mdl[a] = 1; cnt++; end
        else ovf_m = 1;
      end
    end else if (mdl[a]) begin
      mdl[a] = 0; cnt--;
    end
  endtask

  task automatic do_wr(input int a, input logic [31:0] w, input bit comp);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_word = w; wr_compressed = comp;
    @(negedge clk);
    wr_valid = 1'b0;
    model_wr(a, w, comp);
  endtask

  task automatic do_mk(input logic [31:0] v, input bit with_wr, input int a);
    @(negedge clk);
    marker_we = 1'b1; marker_wdata = v;
    wr_valid = with_wr; wr_addr = a; wr_word = v; wr_compressed = 1'b0;
    @(negedge clk);
    marker_we = 1'b0; wr_valid = 1'b0;
    mk = v; ovf_m = 0; cnt = 0;
    for (int i = 0; i < 128; i++) mdl[i] = 0;
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 128; a++) rd_chk(a, mk, tag);
  endtask

  task automatic ovf_chk(input string tag);
    chk(overflow == ovf_m, tag, overflow, ovf_m);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; marker_we = 0; wr_valid = 0; rd_valid = 0; wr_compressed = 0;
    marker_wdata = 0; wr_addr = 0; wr_word = 0; rd_addr = 0; rd_word = 0;
    mk = MK0; cnt = 0; ovf_m = 0;
    for (int i = 0; i < 128; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state, R1: empty table sees pairs
    ovf_chk("R10 overflow after reset");
    sweep("R10 R1 empty table with initial marker");
    // R4: mismatching word, and idle read
    rd_chk(7, MK0 ^ 32'h1, "R4 word mismatch");
    @(negedge clk); #1;
    chk({rd_is_pair, rd_is_collision} == 2'b00, "R4 idle read", {rd_is_pair, rd_is_collision}, 0);

    // R2, R3: fill with duplicates interleaved
    for (int a = 0; a < N; a++) begin
      do_wr(a, mk, 0);
      if (a % 4 == 0) do_wr(a, mk, 0);
      rd_chk(a, mk, "R2 recorded collision");
    end
    ovf_chk("R3 no overflow after distinct fill with repeats");
    do_wr(3, mk, 0);
    ovf_chk("R3 repeat into full table");
    sweep("R2 full table classification");

    // R7: overflow, lost address reads as pair, sticky
    do_wr(40, mk, 0);
    ovf_chk("R7 overflow set");
    rd_chk(40, mk, "R7 lost address reads as pair");

    // R5 / R6 removals and slot reuse
    do_wr(5, 32'h1234_5678, 0);
    rd_chk(5, mk, "R5 removed by mismatching write");
    do_wr(6, mk, 1);
    rd_chk(6, mk, "R6 removed by compressed write");
    do_wr(90, 32'h0, 0);
    sweep("R5 absent removal leaves table");
    do_wr(100, mk, 0);
    do_wr(101, mk, 0);
    ovf_chk("R7 overflow sticky");
    do_wr(102, mk, 0);
    sweep("R2 R7 reuse of freed slots");

    // R8: marker change clears; concurrent write ignored
    do_mk(32'h0BAD_F00D, 1, 20);
    ovf_chk("R8 overflow cleared");
    sweep("R8 table emptied, write ignored");
    rd_chk(2, MK0, "R8 old marker no longer matches");

    // R9: same-cycle read and write
    @(negedge clk);
    wr_valid = 1; wr_addr = 50; wr_word = mk; wr_compressed = 0;
    rd_valid = 1; rd_addr = 50; rd_word = mk;
    #1;
    chk({rd_is_pair, rd_is_collision} == 2'b10, "R9 read sees old state",
        {rd_is_pair, rd_is_collision}, 2);
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    model_wr(50, mk, 0);
    rd_chk(50, mk, "R9 later read sees write");

    // compressed write of a matching word never records (R6)
    do_wr(60, mk, 1);
    sweep("R6 compressed write not recorded");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule